// File: doc/BRIEF.md
# Differential-Leg Test Receiver Capture Cell

This block is the digital back end of a boundary-scan test receiver that sits beside a high-speed mission receiver. It runs at the pin rate, ahead of any deserializer. It receives one already-digitized comparator output for each leg of a differential input. Each leg is handled as its own single-ended signal. Every leg has its own synchronizer, its own edge memory and its own boundary-register cell.

The block has two capture modes. In level mode, used for DC-coupled interconnect tests, the cell records the synchronized level at the pin. In edge mode, used for pulse tests across a coupling capacitor, the cell records the direction of the most recent transition: a rising edge stores 1 and a falling edge stores 0. Before the far end sends its pulse, test control pulses an initialize strobe that loads a known value into every edge memory. If no transition arrives, that value survives. A constant level blocked by a capacitor therefore reads back as the initialized value.

The captured bits load into a shift stage on capture. They leave on a serial chain that runs from the scan input, through leg 0 up to the highest leg, to the scan output. An update stage holds the last shifted contents on parallel outputs.

Top module: `tstrx_capture`

## Requirements
- R1: After reset, every shift-stage bit, every update-stage bit and `tdo` are 0, and every edge memory holds `INIT_VALUE`. A capture in edge mode with no transition since reset returns `INIT_VALUE` on every leg.
- R2: In level mode (`ac_mode`=0), capture loads each leg's shift bit with that leg's comparator level, once the level has been stable for at least `SYNC_STAGES`+1 clocks.
- R3: In edge mode (`ac_mode`=1), a low-to-high transition of a leg's synchronized level sets that leg's edge memory to 1.
- R4: In edge mode, a high-to-low transition of a leg's synchronized level clears that leg's edge memory to 0.
- R5: While a leg's synchronized level does not change and no initialize strobe is present, its edge memory keeps its value, whatever the level is.
- R6: `init_strobe` high at a clock edge loads `INIT_VALUE` into every edge memory. It takes priority over a transition at the same edge.
- R7: After a pulse at least one clock wide, the edge memory holds the direction of the pulse's trailing edge. A high pulse on a low line reads 0 and a low pulse on a high line reads 1.
- R8: Legs are independent. A transition on one leg never changes the captured value of another leg.
- R9: With `shift_dr`=1 and `capture_dr`=0, each shift bit takes the value of the bit below it, leg 0 takes `tdi`, and `tdo` shows the shift bit of leg `LEGS`-1. After a capture, the first bit seen on `tdo` is the highest leg.
- R10: When `capture_dr` and `shift_dr` are both high, capture wins.
- R11: `update_dr` copies the shift stage to `upd_q` (bit i = leg i). Otherwise `upd_q` holds its value, including while shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | LEGS | Comparator outputs, one per leg (asynchronous to clk) |
| ac_mode | input | 1 | 0 = capture level, 1 = capture last edge direction |
| init_strobe | input | 1 | Loads INIT_VALUE into all edge memories |
| capture_dr | input | 1 | Loads the shift stage from the selected source |
| shift_dr | input | 1 | Shifts the chain one place toward tdo |
| update_dr | input | 1 | Copies the shift stage to upd_q |
| tdi | input | 1 | Serial scan input into leg 0 |
| tdo | output | 1 | Serial scan output from the highest leg |
| upd_q | output | LEGS | Update-stage contents |

## Verification
The bench builds the block with two legs, a two-stage synchronizer and an initialize value of 0. This is small enough to sweep every start level against every end level on both legs in both modes. The sweep covers all rising, falling, still and mixed-leg cases. Short pulses in both polarities, capture and shift raised together, and serial patterns through the update stage are then driven with the same two-leg chain. Every bit order and priority can be seen at `tdo` and `upd_q`.

// File: rtl/tstrx_pkg.sv
// Shared definitions for the test receiver capture cell.
package tstrx_pkg;
    // Source the shift stage loads from on capture.
    typedef enum logic {
        CAP_LEVEL = 1'b0,
        CAP_EDGE  = 1'b1
    } cap_mode_e;
endpackage

// File: rtl/tstrx_sync.sv
// Multi-flop synchronizer for one comparator output.
// Assumes the input may change at any time relative to clk.
// The output is the input delayed by STAGES clocks.
module tstrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            // single stage: register the input directly
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= d;
            end
        end else begin : g_many
            // chain of stages: shift the input toward the top bit
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/tstrx_edge_mem.sv
// Edge-direction memory for one leg.
// Assumes lvl is already synchronous to clk. A change in lvl stores the
// new level, so a rising edge stores 1 and a falling edge stores 0.
// The init strobe loads INIT_VALUE and wins over a same-cycle edge.
module tstrx_edge_mem #(
    parameter logic INIT_VALUE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic init_strobe,
    output logic mem_q
);
    logic lvl_d;
    logic edge_seen;

    assign edge_seen = lvl ^ lvl_d;

    // remember previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    // hold direction of last edge, or the initialized value
    always_ff @(posedge clk) begin
        if (!rst_n)          mem_q <= INIT_VALUE;
        else if (init_strobe) mem_q <= INIT_VALUE;
        else if (edge_seen)   mem_q <= lvl;
    end
endmodule

// File: rtl/tstrx_bscell.sv
// Observe-only boundary-register cell: shift stage plus update stage.
// Capture has priority over shift. The update stage changes only on update_en.
module tstrx_bscell (
    input  logic clk,
    input  logic rst_n,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic cap_d,
    input  logic scan_in,
    output logic scan_q,
    output logic upd_q
);
    // shift stage: parallel load on capture, serial load on shift
    always_ff @(posedge clk) begin
        if (!rst_n)          scan_q <= 1'b0;
        else if (capture_en) scan_q <= cap_d;
        else if (shift_en)   scan_q <= scan_in;
    end

    // update stage: copy of shift stage on request
    always_ff @(posedge clk) begin
        if (!rst_n)         upd_q <= 1'b0;
        else if (update_en) upd_q <= scan_q;
    end
endmodule

// File: rtl/tstrx_capture.sv
// Top of the test receiver capture cell: one synchronizer, edge memory
// and boundary cell per leg. The scan chain runs tdi -> leg 0 -> ... ->
// leg LEGS-1 -> tdo. Assumes the comparator outputs are digital levels.
module tstrx_capture
    import tstrx_pkg::*;
#(
    parameter int   LEGS        = 2,
    parameter int   SYNC_STAGES = 2,
    parameter logic INIT_VALUE  = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LEGS-1:0] cmp_in,
    input  logic            ac_mode,
    input  logic            init_strobe,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            tdi,
    output logic            tdo,
    output logic [LEGS-1:0] upd_q
);
    localparam int CHAIN_LEN = LEGS + 1;

    cap_mode_e         mode;
    logic [LEGS-1:0]   sync_lvl;
    logic [LEGS-1:0]   edge_mem;
    logic [LEGS-1:0]   cap_src;
    logic [LEGS-1:0]   scan_q;
    logic [CHAIN_LEN-1:0] chain;

    assign mode     = cap_mode_e'(ac_mode);
    assign chain[0] = tdi;
    assign tdo      = chain[CHAIN_LEN-1];

    generate
        for (genvar i = 0; i < LEGS; i++) begin : g_leg
            tstrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (cmp_in[i]),
                .q     (sync_lvl[i])
            );

            tstrx_edge_mem #(.INIT_VALUE(INIT_VALUE)) u_mem (
                .clk         (clk),
                .rst_n       (rst_n),
                .lvl         (sync_lvl[i]),
                .init_strobe (init_strobe),
                .mem_q       (edge_mem[i])
            );

            // pick level or edge memory per mode
            always_comb begin
                cap_src[i] = (mode == CAP_EDGE) ? edge_mem[i] : sync_lvl[i];
            end

            tstrx_bscell u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .capture_en (capture_dr),
                .shift_en   (shift_dr),
                .update_en  (update_dr),
                .cap_d      (cap_src[i]),
                .scan_in    (chain[i]),
                .scan_q     (scan_q[i]),
                .upd_q      (upd_q[i])
            );

            assign chain[i+1] = scan_q[i];
        end
    endgenerate
endmodule

// File: rtl/tstrx_capture_chk.sv
// Property checker for tstrx_capture, attached with bind.
module tstrx_capture_chk #(
    parameter int   LEGS       = 2,
    parameter logic INIT_VALUE = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ac_mode,
    input logic            init_strobe,
    input logic            capture_dr,
    input logic            shift_dr,
    input logic            update_dr,
    input logic            tdi,
    input logic [LEGS-1:0] sync_lvl,
    input logic [LEGS-1:0] edge_mem,
    input logic [LEGS-1:0] shreg,
    input logic [LEGS-1:0] upd_q
);
    generate
        for (genvar i = 0; i < LEGS; i++) begin : g_chk
            // R3
            rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(sync_lvl[i]) && !init_strobe) |=> edge_mem[i]);
            // R4
            fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(sync_lvl[i]) && !init_strobe) |=> !edge_mem[i]);
            // R5
            quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($stable(sync_lvl[i]) && !init_strobe) |=> $stable(edge_mem[i]));
            // R6
            init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                init_strobe |=> (edge_mem[i] == INIT_VALUE));
            // R10
            capture_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                capture_dr |=> (shreg[i] == ($past(ac_mode) ? $past(edge_mem[i])
                                                            : $past(sync_lvl[i]))));
            // R11
            update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                update_dr |=> (upd_q[i] == $past(shreg[i])));
            // R11
            update_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !update_dr |=> $stable(upd_q[i]));
        end
    endgenerate

    // R9
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_dr && !capture_dr) |=> (shreg[0] == $past(tdi)));
endmodule

bind tstrx_capture tstrx_capture_chk #(
    .LEGS       (LEGS),
    .INIT_VALUE (INIT_VALUE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ac_mode     (ac_mode),
    .init_strobe (init_strobe),
    .capture_dr  (capture_dr),
    .shift_dr    (shift_dr),
    .update_dr   (update_dr),
    .tdi         (tdi),
    .sync_lvl    (sync_lvl),
    .edge_mem    (edge_mem),
    .shreg       (scan_q),
    .upd_q       (upd_q)
);

// File: tb/tstrx_capture_bench.sv
module tstrx_capture_bench;
    localparam int   LEGS = 2;
    localparam logic INITV = 1'b0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LEGS-1:0] cmp_in = '0;
    logic ac_mode = 1'b0, init_strobe = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic tdo;
    logic [LEGS-1:0] upd_q;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tstrx_capture #(.LEGS(LEGS), .SYNC_STAGES(2), .INIT_VALUE(INITV)) u_tstrx_capture (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .ac_mode(ac_mode),
        .init_strobe(init_strobe), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .upd_q(upd_q)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // capture then read both legs out: returns {leg1, leg0}
    task automatic grab(output logic [1:0] v);
        capture_dr = 1'b1;
        cycles(1);
        capture_dr = 1'b0;
        v[1] = tdo;
        shift_dr = 1'b1;
        cycles(1);
        shift_dr = 1'b0;
        v[0] = tdo;
    endtask

    task automatic strobe_init();
        init_strobe = 1'b1;
        cycles(1);
        init_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] v;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check("R1 tdo", tdo, 0);
        check("R1 upd", upd_q, 0);
        ac_mode = 1'b1;
        cycles(2);
        grab(v);
        check("R1 init mem", v, {INITV, INITV});

        // R2 R3 R4 R5 R8: sweep start x end levels in both modes
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int e = 0; e < 4; e++) begin
                    logic [1:0] exp;
                    ac_mode = m[0];
                    cmp_in = s[1:0];
                    cycles(5);
                    strobe_init();
                    cmp_in = e[1:0];
                    cycles(5);
                    grab(v);
                    for (int k = 0; k < 2; k++)
                        exp[k] = (m == 0) ? e[k] : ((s[k] != e[k]) ? e[k] : INITV);
                    if (m == 0) check("R2 level", v, exp);
                    else        check("R3/R4/R5/R8 edge", v, exp);
                end
            end
        end

        // R5: constant high with no edge keeps the init value
        ac_mode = 1'b1;
        cmp_in = 2'b11;
        cycles(5);
        strobe_init();
        cycles(20);
        grab(v);
        check("R5 hold", v, {INITV, INITV});

        // R6: init after an edge restores the init value
        cmp_in = 2'b00;
        cycles(5);
        cmp_in = 2'b01;
        cycles(5);
        strobe_init();
        cycles(2);
        grab(v);
        check("R6 init", v, {INITV, INITV});

        // R7: low pulse on high leg 0 -> 1; high pulse on low leg 1 -> 0
        cmp_in = 2'b01;
        cycles(5);
        strobe_init();
        cmp_in = 2'b10;
        cycles(1);
        cmp_in = 2'b01;
        cycles(5);
        grab(v);
        check("R7 pulse", v, 2'b01);

        // R7: wide high pulse on leg 1 read mid-pulse then after
        cmp_in = 2'b11;
        cycles(5);
        grab(v);
        check("R7 mid", v[1], 1);
        cmp_in = 2'b01;
        cycles(5);
        grab(v);
        check("R7 after", v[1], 0);

        // R10: capture and shift together -> capture wins
        ac_mode = 1'b0;
        cmp_in = 2'b10;
        cycles(5);
        tdi = 1'b0;
        capture_dr = 1'b1;
        shift_dr = 1'b1;
        cycles(1);
        capture_dr = 1'b0;
        shift_dr = 1'b0;
        check("R10 tdo leg1", tdo, 1);

        // R9 R11: shift all four tdi patterns, update, then shift without update
        for (int p = 0; p < 4; p++) begin
            tdi = p[1];
            shift_dr = 1'b1;
            cycles(1);
            tdi = p[0];
            cycles(1);
            shift_dr = 1'b0;
            check("R9 tdo", tdo, p[1]);
            update_dr = 1'b1;
            cycles(1);
            update_dr = 1'b0;
            check("R11 copy", upd_q, {p[1], p[0]});
            tdi = ~p[1];
            shift_dr = 1'b1;
            cycles(2);
            shift_dr = 1'b0;
            check("R11 hold", upd_q, {p[1], p[0]});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule